// File: doc/BRIEF.md
# Shared Memory Bank Conflict Calculator

This unit looks at one warp-wide shared memory request and works out how many serialized memory cycles the request costs. That value is used as the initiation interval of the request. Each lane supplies a byte address and an active bit. The unit turns every address into a word and a bank. It splits the warp into equal sub-warps. For each sub-warp it finds the busiest bank, and it adds the sub-warp results together. The unit moves no data and holds no memory array. Its only job is the cost figure that an issue stage uses to stall.

Two counting policies are available. In distinct-word counting, a bank costs one cycle for each different word requested from it. In limited broadcast, a bank costs one cycle for each thread that hits it. The exception is one word, chosen by a fixed search order, whose repeated hits merge into a single access. The request comes in through a valid/ready handshake. The result goes out one cycle later through a second valid/ready handshake. A held result blocks new requests, so back-pressure from the consumer goes straight through to the producer.

Top module: `bank_conflict_calc`

## Requirements
- R1: `in_ready` is high exactly when no result is waiting. A request taken on `in_valid && in_ready` makes `out_valid` high on the next cycle. Taking the result (`out_valid && out_ready`) with no new request makes `out_valid` low on the next cycle.
- R2: While `out_valid` is high and `out_ready` is low, `out_cycles` and `out_predoff` stay constant and no new request is taken.
- R3: A lane whose `in_mask` bit is 0 has no effect on the result, whatever its address.
- R4: The word of a lane is its address with the low log2(WORD_BYTES) bits cleared. Two addresses that differ only in those bits count as the same word.
- R5: The bank of a lane is the address field of log2(BANKS) bits that sits directly above the word-offset bits.
- R6: With `in_bcast`=0 (distinct-word counting), a sub-warp costs the largest number of different words requested from any one bank.
- R7: With `in_bcast`=1 (limited broadcast), a bank costs the number of active lanes that hit it, and a sub-warp costs the largest such bank cost.
- R8: In limited broadcast, banks are searched in ascending order, and the words within a bank are also searched in ascending order. The first word that more than one lane requests is the only merged word. Its bank cost drops by n-1, where n is the number of lanes hitting that word.
- R9: Sub-warp k is made of lanes k*S to k*S+S-1, where S = LANES/SUBWARPS. Conflicts are never counted across sub-warps. `out_cycles` is the sum of the sub-warp costs.
- R10: For a non-empty mask, `out_cycles` lies between 1 and LANES inclusive.
- R11: A request with an all-zero mask returns `out_cycles`=0 and `out_predoff`=1. Any other request returns `out_predoff`=0.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The unit can take a request |
| in_mask | input | LANES | Active bit for each lane |
| in_addr | input | LANES*ADDR_W | Byte address for each lane; lane i is at bits [i*ADDR_W +: ADDR_W] |
| in_bcast | input | 1 | 1 selects limited broadcast, 0 selects distinct-word counting |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result |
| out_cycles | output | $clog2(LANES+1) | Serialized cycle count |
| out_predoff | output | 1 | The request had no active lane |

## Verification
The handshake properties assume that the producer keeps `in_valid` and the request fields steady only up to the edge where the request is taken. They make no assumption about a request that is offered while a result is held. The bench deliberately offers such requests and checks that they are not taken. The range property assumes that the parameters divide the warp into equal sub-warps and that BANKS and WORD_BYTES are powers of two; the bench parameter set meets these conditions. The directed cases give every lane an address inside a small window, so that bank and word collisions are frequent. The random phase draws addresses from 64 bytes (16 words across 4 banks), and it drives both `in_bcast` and `out_ready` at random.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic {
    POL_DISTINCT = 1'b0,
    POL_BCAST    = 1'b1
  } policy_e;
endpackage

// File: rtl/bcc_lane_map.sv
module bcc_lane_map #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 4,
  parameter int BANKS      = 32
) (
  input  logic [LANES*ADDR_W-1:0]          addr_flat,
  output logic [LANES*ADDR_W-1:0]          word_flat,
  output logic [LANES*$clog2(BANKS)-1:0]   bank_flat
);
  localparam int WOFF_W = $clog2(WORD_BYTES);
  localparam int BANK_W = $clog2(BANKS);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(WORD_BYTES - 1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] word_addr;
    assign word_addr = addr_flat[l*ADDR_W +: ADDR_W] & ~OFF_MASK;
    assign word_flat[l*ADDR_W +: ADDR_W] = word_addr;
    assign bank_flat[l*BANK_W +: BANK_W] = word_addr[WOFF_W +: BANK_W];
  end
endmodule

// File: rtl/bcc_subwarp_cost.sv
module bcc_subwarp_cost #(
  parameter int SW_LANES = 16,
  parameter int WORD_W   = 16,
  parameter int BANK_W   = 5,
  parameter int COST_W   = 5
) (
  input  logic [SW_LANES-1:0]        sw_mask,
  input  logic [SW_LANES*WORD_W-1:0] sw_word,
  input  logic [SW_LANES*BANK_W-1:0] sw_bank,
  input  logic                       bcast,
  output logic [COST_W-1:0]          cost
);
  localparam int BANKS = 1 << BANK_W;

  logic [WORD_W-1:0] w  [SW_LANES];
  logic [BANK_W-1:0] bk [SW_LANES];
  logic [COST_W-1:0] hits [SW_LANES];
  logic [SW_LANES-1:0] first, cand, take;
  logic              found;
  logic [WORD_W-1:0] sel_w;
  logic [BANK_W-1:0] sel_b;
  logic [COST_W-1:0] bank_cnt [BANKS];

  for (genvar l = 0; l < SW_LANES; l++) begin : g_unpack
    assign w[l]  = sw_word[l*WORD_W +: WORD_W];
    assign bk[l] = sw_bank[l*BANK_W +: BANK_W];
  end

  // First occurrence of each word and number of lanes sharing it
  always_comb begin
    for (int i = 0; i < SW_LANES; i++) begin
      first[i] = sw_mask[i];
      hits[i]  = '0;
      for (int j = 0; j < SW_LANES; j++) begin
        if (sw_mask[j] && (w[j] == w[i])) begin
          hits[i] = hits[i] + COST_W'(1);
          if (j < i) first[i] = 1'b0;
        end
      end
      cand[i] = first[i] && (hits[i] > COST_W'(1));
    end
  end

  // Lowest {bank, word} among the shared words
  always_comb begin
    found = 1'b0;
    sel_w = '0;
    sel_b = '0;
    for (int i = 0; i < SW_LANES; i++) begin
      if (cand[i] && (!found || ({bk[i], w[i]} < {sel_b, sel_w}))) begin
        found = 1'b1;
        sel_w = w[i];
        sel_b = bk[i];
      end
    end
  end

  // Lanes that cost a bank slot under the chosen policy
  always_comb begin
    for (int i = 0; i < SW_LANES; i++) begin
      if (bcast)
        take[i] = sw_mask[i] && !(found && !first[i] && (w[i] == sel_w));
      else
        take[i] = first[i];
    end
  end

  always_comb begin
    cost = '0;
    for (int b = 0; b < BANKS; b++) begin
      bank_cnt[b] = '0;
      for (int i = 0; i < SW_LANES; i++) begin
        if (take[i] && (bk[i] == BANK_W'(b)))
          bank_cnt[b] = bank_cnt[b] + COST_W'(1);
      end
      if (bank_cnt[b] > cost) cost = bank_cnt[b];
    end
  end
endmodule

// File: rtl/bank_conflict_calc.sv
module bank_conflict_calc
  import bcc_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int BANKS      = 32,
  parameter int WORD_BYTES = 4,
  parameter int SUBWARPS   = 2,
  parameter int ADDR_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [LANES-1:0]           in_mask,
  input  logic [LANES*ADDR_W-1:0]    in_addr,
  input  logic                       in_bcast,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [$clog2(LANES+1)-1:0] out_cycles,
  output logic                       out_predoff
);
  localparam int SW_LANES = LANES / SUBWARPS;
  localparam int BANK_W   = $clog2(BANKS);
  localparam int COST_W   = $clog2(SW_LANES + 1);
  localparam int CNT_W    = $clog2(LANES + 1);

  logic [LANES*ADDR_W-1:0] word_flat;
  logic [LANES*BANK_W-1:0] bank_flat;
  logic [COST_W-1:0]       sw_cost [SUBWARPS];
  logic [CNT_W-1:0]        total;
  policy_e                 pol;

  logic                    res_valid;
  logic [CNT_W-1:0]        res_cycles;
  logic                    res_pred;

  assign pol = in_bcast ? POL_BCAST : POL_DISTINCT;

  bcc_lane_map #(
    .LANES(LANES), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BANKS(BANKS)
  ) u_map (
    .addr_flat(in_addr),
    .word_flat(word_flat),
    .bank_flat(bank_flat)
  );

  for (genvar s = 0; s < SUBWARPS; s++) begin : g_sw
    bcc_subwarp_cost #(
      .SW_LANES(SW_LANES), .WORD_W(ADDR_W), .BANK_W(BANK_W), .COST_W(COST_W)
    ) u_cost (
      .sw_mask(in_mask[s*SW_LANES +: SW_LANES]),
      .sw_word(word_flat[s*SW_LANES*ADDR_W +: SW_LANES*ADDR_W]),
      .sw_bank(bank_flat[s*SW_LANES*BANK_W +: SW_LANES*BANK_W]),
      .bcast(pol == POL_BCAST),
      .cost(sw_cost[s])
    );
  end

  always_comb begin
    total = '0;
    for (int s = 0; s < SUBWARPS; s++)
      total = total + CNT_W'(sw_cost[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_cycles <= '0;
      res_pred   <= 1'b0;
    end else begin
      if (res_valid && out_ready)
        res_valid <= 1'b0;
      if (in_valid && !res_valid) begin
        res_valid  <= 1'b1;
        res_cycles <= total;
        res_pred   <= ~|in_mask;
      end
    end
  end

  assign in_ready    = !res_valid;
  assign out_valid   = res_valid;
  assign out_cycles  = res_cycles;
  assign out_predoff = res_pred;
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
  parameter int LANES = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [LANES-1:0]           in_mask,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [$clog2(LANES+1)-1:0] out_cycles,
  input logic                       out_predoff
);
  AST_ACCEPT_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R1

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R1

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cycles) && $stable(out_predoff))); // R2

  AST_CYCLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_predoff) |-> ((out_cycles != '0) && (int'(out_cycles) <= LANES))); // R10

  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_mask == '0)) |=> (out_predoff && (out_cycles == '0))); // R11

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_predoff == (out_cycles == '0))); // R11
endmodule

bind bank_conflict_calc bcc_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mask(in_mask), .out_valid(out_valid), .out_ready(out_ready),
  .out_cycles(out_cycles), .out_predoff(out_predoff)
);

// File: tb/sim_bank_conflict_calc.sv
`timescale 1ns/1ps
module sim_bank_conflict_calc;
  localparam int TL  = 16;
  localparam int TB  = 4;
  localparam int TWB = 4;
  localparam int TSW = 2;
  localparam int TAW = 12;
  localparam int SWL = TL / TSW;
  localparam int CW  = $clog2(TL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [TL-1:0] in_mask = '0;
  logic [TL*TAW-1:0] in_addr;
  logic in_bcast = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [CW-1:0] out_cycles;
  logic out_predoff;

  logic [TAW-1:0] tb_addr [TL];
  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R12";
  bit done = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < TL; i++) in_addr[i*TAW +: TAW] = tb_addr[i];

  bank_conflict_calc #(
    .LANES(TL), .BANKS(TB), .WORD_BYTES(TWB), .SUBWARPS(TSW), .ADDR_W(TAW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_addr(in_addr), .in_bcast(in_bcast),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_cycles(out_cycles), .out_predoff(out_predoff)
  );

  function automatic int word_of(int l);
    return int'(tb_addr[l]) / TWB;
  endfunction

  function automatic int bank_of(int l);
    return word_of(l) % TB;
  endfunction

  function automatic int ref_cost(logic [TL-1:0] m, logic bc);
    int total;
    total = 0;
    for (int s = 0; s < TSW; s++) begin
      int bw; int bb; int bn; int best;
      bw = -1; bb = -1; bn = 0; best = 0;
      if (bc) begin
        for (int b = 0; b < TB; b++) begin
          int ws[$];
          ws = {};
          for (int l = s*SWL; l < (s+1)*SWL; l++)
            if (m[l] && bank_of(l) == b) ws.push_back(word_of(l));
          ws.sort();
          foreach (ws[k]) begin
            if (bw < 0) begin
              int c;
              c = 0;
              foreach (ws[q]) if (ws[q] == ws[k]) c++;
              if (c > 1) begin bw = ws[k]; bb = b; bn = c; end
            end
          end
        end
      end
      for (int b = 0; b < TB; b++) begin
        int tot; int uq[$]; int cst;
        tot = 0; uq = {};
        for (int l = s*SWL; l < (s+1)*SWL; l++) begin
          if (m[l] && bank_of(l) == b) begin
            bit seen;
            seen = 0;
            tot++;
            foreach (uq[u]) if (uq[u] == word_of(l)) seen = 1;
            if (!seen) uq.push_back(word_of(l));
          end
        end
        cst = bc ? (tot - ((b == bb) ? bn - 1 : 0)) : uq.size();
        if (cst > best) best = cst;
      end
      total += best;
    end
    return total;
  endfunction

  // Cycle reference model
  bit mv = 0;
  int mc = 0;
  bit mp = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mv <= 0;
    end else begin
      if (mv && out_ready) mv <= 0;
      if (!mv && in_valid) begin
        mv <= 1;
        mc <= ref_cost(in_mask, in_bcast);
        mp <= (in_mask == '0);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (out_valid !== mv || in_ready !== !mv) begin
        n_bad++;
        $display("FAIL %s handshake: out_valid=%0b in_ready=%0b expected out_valid=%0b in_ready=%0b",
                 cur_req, out_valid, in_ready, mv, !mv);
      end
      if (mv) begin
        n_chk++;
        if (int'(out_cycles) != mc || out_predoff !== mp) begin
          n_bad++;
          $display("FAIL %s model: cycles=%0d predoff=%0b expected cycles=%0d predoff=%0b",
                   cur_req, out_cycles, out_predoff, mc, mp);
        end
      end
    end
  end

  task automatic send(input logic [TL-1:0] m, input logic bc, input int exp, input string req);
    cur_req = req;
    @(negedge clk);
    in_mask = m; in_bcast = bc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_chk++;
    if (out_valid !== 1'b1 || int'(out_cycles) != exp || out_predoff !== (m == '0)) begin
      n_bad++;
      $display("FAIL %s directed: valid=%0b cycles=%0d predoff=%0b expected valid=1 cycles=%0d predoff=%0b",
               req, out_valid, out_cycles, out_predoff, exp, (m == '0));
    end
  endtask

  task automatic fill(input int base, input int stride);
    for (int i = 0; i < TL; i++) tb_addr[i] = TAW'(base + stride * i);
  endtask

  task automatic finish_up;
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_up();
  end

  initial begin
    fill(0, 4);
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R12 reset: out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);

    fill(0, 4);    send('1, 1'b0, 4, "R6"); send('1, 1'b1, 4, "R7");
    fill(32, 0);   send('1, 1'b0, 2, "R6"); send('1, 1'b1, 2, "R8");
    fill(0, 16);   send('1, 1'b0, 16, "R10"); send('1, 1'b1, 16, "R10");
    for (int i = 0; i < TL; i++) tb_addr[i] = TAW'(64 + (i % 4));
    send('1, 1'b0, 2, "R4");
    fill(0, 0); tb_addr[1] = 12'h040; send(16'h0003, 1'b0, 2, "R5");
    tb_addr[1] = 12'h044; send(16'h0003, 1'b0, 1, "R5");
    // ascending word inside a bank
    fill(0, 0);
    tb_addr[0] = 12'h024; tb_addr[1] = 12'h024; tb_addr[2] = 12'h024;
    tb_addr[3] = 12'h004; tb_addr[4] = 12'h004;
    tb_addr[5] = 12'h008; tb_addr[6] = 12'h018; tb_addr[7] = 12'h028;
    send(16'h00FF, 1'b1, 4, "R8"); send(16'h00FF, 1'b0, 3, "R6");
    // ascending bank order
    tb_addr[0] = 12'h004; tb_addr[1] = 12'h004; tb_addr[2] = 12'h014;
    tb_addr[3] = 12'h010; tb_addr[4] = 12'h010; tb_addr[5] = 12'h010;
    tb_addr[6] = 12'h020; tb_addr[7] = 12'h030;
    send(16'h00FF, 1'b1, 3, "R8"); send(16'h00FF, 1'b0, 3, "R6");
    // only one word merged
    tb_addr[0] = 12'h010; tb_addr[1] = 12'h010; tb_addr[2] = 12'h020; tb_addr[3] = 12'h020;
    send(16'h000F, 1'b1, 3, "R8"); send(16'h000F, 1'b0, 2, "R6");
    fill(0, 16);   send(16'h0101, 1'b0, 2, "R3"); send(16'h0101, 1'b1, 2, "R3");
    fill(0, 0);    send(16'h0180, 1'b1, 2, "R9"); send(16'h0180, 1'b0, 2, "R9");
    send(16'h0000, 1'b1, 0, "R11");

    // back-pressure: held result, competing request not taken
    cur_req = "R2";
    @(negedge clk);
    out_ready = 1'b0; fill(0, 16); in_mask = '1; in_bcast = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    fill(0, 4); in_mask = 16'h0001;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b1 || out_cycles != CW'(16)) begin
      n_bad++;
      $display("FAIL R2 hold: valid=%0b cycles=%0d expected 1 16", out_valid, out_cycles);
    end
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n_chk++;
    if (out_valid !== 1'b1 || out_cycles != CW'(1)) begin
      n_bad++;
      $display("FAIL R1 next request: valid=%0b cycles=%0d expected 1 1", out_valid, out_cycles);
    end
    @(negedge clk);

    // random traffic against the model
    cur_req = "R9";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (in_ready || !in_valid) begin
        for (int i = 0; i < TL; i++) tb_addr[i] = TAW'($urandom % 64);
        in_mask  = TL'($urandom);
        if (($urandom % 8) == 0) in_mask = '0;
        in_bcast = 1'($urandom);
        in_valid = 1'($urandom);
      end
      out_ready = (($urandom % 4) != 0);
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule